// File: doc/BRIEF.md
# Keyboard and Display Register Interface

This block is a bus slave that gives a processor access to a keyboard and a character display through four 32-bit registers in one aligned 16-byte window. The base of the window is a parameter. A comparator on the upper address bits, together with a word-alignment test, decides whether the block answers a bus cycle. Reads are combinational and take effect in the same cycle. Writes and the side effect of a read take effect at the next rising clock edge.

On the keyboard side, a byte arriving on a ready/valid input port is latched into a holding register, and a ready flag is raised. The flag drops when the processor reads the keyboard data register. While the flag is up, the input port stalls. On the display side, a processor write to the display data register places the byte on a ready/valid output port and drops the display ready flag. The flag comes back when the display takes the byte. Each device has its own interrupt-enable bit, and one interrupt request line combines the two devices.

Top module: `kbdisp_io`

## Requirements
- R1: The block answers only when `bus_sel` is high, address bits 31:4 equal those of `BASE_ADDR` and address bits 1:0 are zero. Otherwise `bus_hit` is low, `bus_rdata` is zero and no register state changes.
- R2: Address bits 3:2 pick the register: 0 keyboard status, 1 keyboard data, 2 display status, 3 display data. `bus_rdata` carries the register only on a hit with `bus_we` low, and is zero otherwise.
- R3: In both status registers, bit 0 is the ready flag and bit 1 is the interrupt enable. Bits 31:2 read as zero. A write changes only bit 1, which takes `bus_wdata[1]`.
- R4: Both data registers return their byte in bits 7:0, with bits 31:8 reading zero. A write to the keyboard data register has no effect.
- R5: `kbd_in_ready` is the inverse of the keyboard ready flag. A byte offered with `kbd_in_valid` while `kbd_in_ready` is high is latched, and the flag reads 1 from the next cycle on.
- R6: A read of the keyboard data register clears the keyboard ready flag at the following edge.
- R7: A write to the display data register while the display ready flag is 1 drives `bus_wdata[7:0]` on `disp_out_byte` with `disp_out_valid` high from the next cycle, and the flag reads 0.
- R8: `disp_out_valid` and `disp_out_byte` hold steady until `disp_out_ready` is seen high. After that, valid drops and the display ready flag reads 1 in the next cycle.
- R9: A write to the display data register while a byte is still pending is ignored, and the pending byte is unchanged.
- R10: `irq` is high exactly when some device has both its ready flag and its interrupt enable set.
- R11: After reset, the keyboard ready flag and both enables are 0, the display ready flag is 1 and both data bytes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus cycle valid |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_hit | output | 1 | Address decoded to this block |
| kbd_in_valid | input | 1 | Keyboard byte offered |
| kbd_in_byte | input | 8 | Keyboard byte |
| kbd_in_ready | output | 1 | Holding register empty |
| disp_out_valid | output | 1 | Display byte pending |
| disp_out_byte | output | 8 | Display byte |
| disp_out_ready | input | 1 | Display takes the byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a base of 0xffff0000 on a 32-bit address, and 32-bit registers holding 8-bit bytes. With these values, a random address that falls inside the window, just outside it or off-alignment lands on each decode branch often. Most random addresses land inside the window, so keyboard arrivals, data-register reads, display writes and display stalls collide in the same cycle. This reaches the load-versus-read and busy-write orderings, as well as the single-cycle handoffs on both byte ports.

// File: rtl/kbdisp_pkg.sv
package kbdisp_pkg;
  parameter int REG_W  = 32;
  parameter int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_KSTAT = 2'd0,
    SEL_KDATA = 2'd1,
    SEL_DSTAT = 2'd2,
    SEL_DDATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ie;
    logic ready;
  } dev_stat_t;

  // status word: bit 0 ready, bit 1 interrupt enable, rest zero
  function automatic logic [REG_W-1:0] pack_stat(dev_stat_t s);
    logic [REG_W-1:0] w;
    w    = '0;
    w[0] = s.ready;
    w[1] = s.ie;
    return w;
  endfunction

  // data word: byte in the low bits, rest zero
  function automatic logic [REG_W-1:0] pack_byte(logic [BYTE_W-1:0] b);
    logic [REG_W-1:0] w;
    w            = '0;
    w[BYTE_W-1:0] = b;
    return w;
  endfunction

  function automatic logic irq_of(dev_stat_t a, dev_stat_t b);
    return (a.ready & a.ie) | (b.ready & b.ie);
  endfunction
endpackage

// File: rtl/kbdisp_decode.sv
module kbdisp_decode
  import kbdisp_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hffff_0000
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit,
  output reg_sel_e          sel,
  output logic              rd_en,
  output logic              wr_en
);
  localparam int WIN_LSB = 4;

  logic base_match;
  logic aligned;

  assign base_match = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign hit        = bus_sel & base_match & aligned;
  assign sel        = reg_sel_e'(bus_addr[3:2]);
  assign rd_en      = hit & ~bus_we;
  assign wr_en      = hit & bus_we;
endmodule

// File: rtl/kbdisp_kbd_chan.sv
module kbdisp_kbd_chan
  import kbdisp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [BYTE_W-1:0] key_byte,
  input  logic              take,
  input  logic              ie_wr,
  input  logic              ie_val,
  output logic              key_ready,
  output dev_stat_t         stat,
  output logic [BYTE_W-1:0] byte_q,
  output logic              load
);
  logic flag_q;
  logic ie_q;

  assign load      = key_valid & ~flag_q;
  assign key_ready = ~flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      if (ie_wr) ie_q <= ie_val;
      if (load) begin
        flag_q <= 1'b1;
        byte_q <= key_byte;
      end else if (take) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign stat.ready = flag_q;
  assign stat.ie    = ie_q;
endmodule

// File: rtl/kbdisp_disp_chan.sv
module kbdisp_disp_chan
  import kbdisp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic              ie_wr,
  input  logic              ie_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output dev_stat_t         stat,
  output logic              push,
  output logic              pop
);
  logic pend_q;
  logic ie_q;

  assign push = push_req & ~pend_q;
  assign pop  = pend_q & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      ie_q     <= 1'b0;
      out_byte <= '0;
    end else begin
      if (ie_wr) ie_q <= ie_val;
      if (push) begin
        pend_q   <= 1'b1;
        out_byte <= push_byte;
      end else if (pop) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign out_valid  = pend_q;
  assign stat.ready = ~pend_q;
  assign stat.ie    = ie_q;
endmodule

// File: rtl/kbdisp_io.sv
module kbdisp_io
  import kbdisp_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hffff_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_hit,
  input  logic              kbd_in_valid,
  input  logic [BYTE_W-1:0] kbd_in_byte,
  output logic              kbd_in_ready,
  output logic              disp_out_valid,
  output logic [BYTE_W-1:0] disp_out_byte,
  input  logic              disp_out_ready,
  output logic              irq
);
  reg_sel_e          sel;
  logic              rd_en, wr_en;
  dev_stat_t         kbd_stat, disp_stat;
  logic [BYTE_W-1:0] kbd_byte;

  // named internal events, brought out for the checker
  logic kbd_load, kbd_take, disp_wr_req, disp_push, disp_pop;
  logic kbd_flag, kbd_ie, disp_ie;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata[REG_W-1:BYTE_W]};

  kbdisp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .hit     (bus_hit),
    .sel     (sel),
    .rd_en   (rd_en),
    .wr_en   (wr_en)
  );

  assign kbd_take    = rd_en & (sel == SEL_KDATA);
  assign disp_wr_req = wr_en & (sel == SEL_DDATA);

  kbdisp_kbd_chan u_kbd (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_valid(kbd_in_valid),
    .key_byte (kbd_in_byte),
    .take     (kbd_take),
    .ie_wr    (wr_en & (sel == SEL_KSTAT)),
    .ie_val   (bus_wdata[1]),
    .key_ready(kbd_in_ready),
    .stat     (kbd_stat),
    .byte_q   (kbd_byte),
    .load     (kbd_load)
  );

  kbdisp_disp_chan u_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (disp_wr_req),
    .push_byte(bus_wdata[BYTE_W-1:0]),
    .ie_wr    (wr_en & (sel == SEL_DSTAT)),
    .ie_val   (bus_wdata[1]),
    .out_ready(disp_out_ready),
    .out_valid(disp_out_valid),
    .out_byte (disp_out_byte),
    .stat     (disp_stat),
    .push     (disp_push),
    .pop      (disp_pop)
  );

  assign kbd_flag = kbd_stat.ready;
  assign kbd_ie   = kbd_stat.ie;
  assign disp_ie  = disp_stat.ie;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_KSTAT: bus_rdata = pack_stat(kbd_stat);
        SEL_KDATA: bus_rdata = pack_byte(kbd_byte);
        SEL_DSTAT: bus_rdata = pack_stat(disp_stat);
        SEL_DDATA: bus_rdata = pack_byte(disp_out_byte);
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq = irq_of(kbd_stat, disp_stat);
endmodule

// File: rtl/kbdisp_io_chk.sv
module kbdisp_io_chk
  import kbdisp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_hit,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              irq,
  input logic              kbd_load,
  input logic              kbd_take,
  input logic              kbd_flag,
  input logic              kbd_ie,
  input logic              disp_ie,
  input logic              disp_wr_req,
  input logic              disp_push,
  input logic              disp_out_valid,
  input logic              disp_out_ready,
  input logic [BYTE_W-1:0] disp_out_byte
);
  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_hit |-> bus_rdata == '0);

  assert_key_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_load |=> kbd_flag);

  assert_key_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_take && !kbd_load) |=> !kbd_flag);

  assert_disp_show_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_push |=> disp_out_valid);

  assert_disp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_out_valid && !disp_out_ready) |=> (disp_out_valid && $stable(disp_out_byte)));

  assert_disp_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_out_valid && disp_out_ready) |=> !disp_out_valid);

  assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_wr_req && disp_out_valid) |=> $stable(disp_out_byte));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!kbd_ie && !disp_ie) |-> !irq);
endmodule

bind kbdisp_io kbdisp_io_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_hit       (bus_hit),
  .bus_rdata     (bus_rdata),
  .irq           (irq),
  .kbd_load      (kbd_load),
  .kbd_take      (kbd_take),
  .kbd_flag      (kbd_flag),
  .kbd_ie        (kbd_ie),
  .disp_ie       (disp_ie),
  .disp_wr_req   (disp_wr_req),
  .disp_push     (disp_push),
  .disp_out_valid(disp_out_valid),
  .disp_out_ready(disp_out_ready),
  .disp_out_byte (disp_out_byte)
);

// File: tb/tb_kbdisp_io.sv
`timescale 1ns/1ps
module tb_kbdisp_io;
  localparam logic [31:0] BASE  = 32'hffff_0000;
  localparam logic [31:0] KSTAT = BASE + 32'h0;
  localparam logic [31:0] KDATA = BASE + 32'h4;
  localparam logic [31:0] DSTAT = BASE + 32'h8;
  localparam logic [31:0] DDATA = BASE + 32'hc;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_hit;
  logic        kbd_in_valid;
  logic [7:0]  kbd_in_byte;
  logic        kbd_in_ready;
  logic        disp_out_valid;
  logic [7:0]  disp_out_byte;
  logic        disp_out_ready;
  logic        irq;

  always #2 clk = ~clk;

  kbdisp_io dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_hit(bus_hit), .kbd_in_valid(kbd_in_valid), .kbd_in_byte(kbd_in_byte),
    .kbd_in_ready(kbd_in_ready), .disp_out_valid(disp_out_valid),
    .disp_out_byte(disp_out_byte), .disp_out_ready(disp_out_ready), .irq(irq)
  );

  int vectors = 0;
  int fails   = 0;

  // reference state
  logic       m_kr, m_kie, m_dp, m_die;
  logic [7:0] m_kb, m_db;
  // last sampled outputs
  logic       s_irq, s_hit, s_valid;
  logic [7:0] s_byte;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_hit(input logic sel, input logic [31:0] a);
    return sel && (a[31:4] == BASE[31:4]) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] exp_reg(input logic [1:0] idx);
    case (idx)
      2'd0:    return {30'd0, m_kie, m_kr};
      2'd1:    return {24'd0, m_kb};
      2'd2:    return {30'd0, m_die, ~m_dp};
      default: return {24'd0, m_db};
    endcase
  endfunction

  function automatic string reg_tag(input logic [1:0] idx);
    return idx[0] ? "R4" : "R3";
  endfunction

  // one bus cycle: drive at negedge, check, advance the model, wait for the edge
  task automatic step(input logic sel, input logic we, input logic [31:0] a,
                      input logic [31:0] wd, input logic kv, input logic [7:0] kb,
                      input logic dr, output logic [31:0] rd);
    logic h;
    logic [31:0] er;
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    kbd_in_valid = kv; kbd_in_byte = kb; disp_out_ready = dr;
    #1;
    h  = exp_hit(sel, a);
    er = (h && !we) ? exp_reg(a[3:2]) : 32'd0;
    chk("R1 hit", {31'd0, bus_hit}, {31'd0, h});
    if (h && !we) chk({reg_tag(a[3:2]), " R2 rdata"}, bus_rdata, er);
    else          chk("R1 R2 rdata zero", bus_rdata, 32'd0);
    chk("R5 kbd_in_ready", {31'd0, kbd_in_ready}, {31'd0, ~m_kr});
    chk("R7 disp_out_valid", {31'd0, disp_out_valid}, {31'd0, m_dp});
    chk("R8 disp_out_byte", {24'd0, disp_out_byte}, {24'd0, m_db});
    chk("R10 irq", {31'd0, irq}, {31'd0, (m_kr & m_kie) | (~m_dp & m_die)});
    rd = bus_rdata; s_irq = irq; s_hit = bus_hit; s_valid = disp_out_valid; s_byte = disp_out_byte;
    // model update from pre-edge state
    if (h && we && a[3:2] == 2'd0) m_kie = wd[1];
    if (h && we && a[3:2] == 2'd2) m_die = wd[1];
    if (kv && !m_kr) begin m_kr = 1'b1; m_kb = kb; end
    else if (h && !we && a[3:2] == 2'd1) m_kr = 1'b0;
    if (h && we && a[3:2] == 2'd3 && !m_dp) begin m_dp = 1'b1; m_db = wd[7:0]; end
    else if (m_dp && dr) m_dp = 1'b0;
    @(posedge clk);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic dr);
    logic [31:0] x;
    step(1'b1, 1'b1, a, d, 1'b0, 8'h00, dr, x);
  endtask

  task automatic rd(input logic [31:0] a, input logic dr, output logic [31:0] d);
    step(1'b1, 1'b0, a, 32'd0, 1'b0, 8'h00, dr, d);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d, x;
    void'($urandom(32'd20250));
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    kbd_in_valid = 0; kbd_in_byte = 0; disp_out_ready = 0;
    m_kr = 0; m_kie = 0; m_dp = 0; m_die = 0; m_kb = 0; m_db = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 kbd_in_ready", {31'd0, kbd_in_ready}, 32'd1);
    chk("R11 disp_out_valid", {31'd0, disp_out_valid}, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    rd(KSTAT, 0, d); chk("R11 kbd status", d, 32'h0);
    rd(DSTAT, 0, d); chk("R11 disp status", d, 32'h1);
    rd(KDATA, 0, d); chk("R11 kbd byte", d, 32'h0);
    rd(DDATA, 0, d); chk("R11 disp byte", d, 32'h0);

    // keyboard arrival and consumption
    step(1'b0, 1'b0, 32'd0, 32'd0, 1'b1, 8'h5a, 1'b0, x);
    rd(KSTAT, 0, d); chk("R5 flag set", d, 32'h1);
    rd(KDATA, 0, d); chk("R4 kbd byte", d, 32'h5a);
    rd(KSTAT, 0, d); chk("R6 flag cleared", d, 32'h0);

    // status write: only the enable bit sticks
    wr(KSTAT, 32'hffff_ffff, 0);
    rd(KSTAT, 0, d); chk("R3 only ie writable", d, 32'h2);
    chk("R10 irq low with flag clear", {31'd0, s_irq}, 32'd0);
    step(1'b0, 1'b0, 32'd0, 32'd0, 1'b1, 8'hc3, 1'b0, x);
    rd(KSTAT, 0, d); chk("R10 irq with kbd ready", {31'd0, s_irq}, 32'd1);
    wr(KDATA, 32'h0000_00ff, 0);
    rd(KDATA, 0, d); chk("R4 kbd data write ignored", d, 32'hc3);
    wr(KSTAT, 32'h0, 0);

    // display path with a stalled sink
    wr(DDATA, 32'h1234_56a5, 0);
    rd(DSTAT, 0, d); chk("R7 disp flag cleared", d, 32'h0);
    chk("R7 byte shown", {24'd0, s_byte}, 32'ha5);
    wr(DDATA, 32'h0000_0077, 0);
    rd(DDATA, 0, d); chk("R9 busy write ignored", d, 32'ha5);
    step(1'b0, 1'b0, 32'd0, 32'd0, 1'b0, 8'h00, 1'b1, x);
    rd(DSTAT, 0, d); chk("R8 flag back after accept", d, 32'h1);
    chk("R8 valid dropped", {31'd0, s_valid}, 32'd0);
    wr(DSTAT, 32'h2, 0);
    rd(DSTAT, 0, d); chk("R10 irq from display", {31'd0, s_irq}, 32'd1);
    wr(DSTAT, 32'h0, 0);

    // decode misses
    step(1'b1, 1'b1, 32'hfffe_000c, 32'h33, 1'b0, 8'h00, 1'b0, x);
    chk("R1 outside window", {31'd0, s_hit}, 32'd0);
    step(1'b1, 1'b1, 32'hffff_000d, 32'h33, 1'b0, 8'h00, 1'b0, x);
    chk("R1 misaligned", {31'd0, s_hit}, 32'd0);
    step(1'b0, 1'b1, DDATA, 32'h33, 1'b0, 8'h00, 1'b0, x);
    chk("R1 no write taken", {31'd0, s_valid}, 32'd0);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      int r;
      r = int'($urandom % 10);
      if (r < 8)       a = BASE | (($urandom % 4) << 2);
      else if (r == 8) a = $urandom;
      else             a = BASE | ($urandom & 32'hf);
      step(($urandom % 4) != 0, $urandom % 2, a, $urandom,
           ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) != 0, x);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule